// File: doc/BRIEF.md
# Multicore Interrupt Steering Controller

This block steers interrupt requests toward a cluster of processor cores. Every core has a normal-priority request output and a fast-request output. It takes four level-sensitive local timer lines per core, a 4-bit pending vector per core from an external mailbox unit, and one shared upstream normal line plus one shared upstream fast line. Software writes a per-core enable byte for the timer group and one for the mailbox group. It also writes a routing register that picks which core gets each shared line.

Each enabled source goes to exactly one output class. When both enables of a source are set, the fast class takes it. The per-core source words are built combinationally from the live inputs and the stored controls, and software can read them back. An output is high when its source word is nonzero. Access is through a simple 32-bit register port that completes a read or write in one cycle and uses an 8-bit byte offset.

Top module: `irq_steer_top`

## Requirements
- R1: After reset the routing register (offset 0x0C) reads 0 and all timer enables (0x40..0x4F) and mailbox enables (0x50..0x5F) read 0. All outputs are low.
- R2: Routing register 0x0C stores only bits [1:0], the core index for the shared normal line, and bits [3:2], the core index for the shared fast line. Reads return these bits in the same positions and zero elsewhere.
- R3: Each enable register stores only write-data bits [7:0]. The register for core c sits at base + 4*c, and offset bits [1:0] are ignored.
- R4: In an enable byte, bit j enables normal delivery of source j and bit j+4 enables fast delivery, for j = 0..3. If both bits are set the source goes to the fast word only. If neither is set the source reaches no word.
- R5: Source word layout: bits [3:0] are timer lines 0..3, bits [7:4] are mailbox pending bits 0..3, and bit 8 is the shared upstream source. Bits [31:9] always read 0.
- R6: The shared normal line sets bit 8 only in the normal word of the core selected by 0x0C[1:0]. The shared fast line sets bit 8 only in the fast word of the core selected by 0x0C[3:2].
- R7: Normal words are read at 0x60 + 4*c and fast words at 0x70 + 4*c. They follow the inputs in the same cycle, with no latching.
- R8: Output irq_o[c] equals (normal word c != 0) and fiq_o[c] equals (fast word c != 0), combinationally.
- R9: A read returns data in the cycle of the request. Unmapped offsets read 0, and writes to them change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| timer_i | input | 16 | Timer lines, core c at [4c+3:4c] |
| mbox_i | input | 16 | Mailbox pending, core c at [4c+3:4c] |
| shared_irq_i | input | 1 | Shared upstream normal line |
| shared_fiq_i | input | 1 | Shared upstream fast line |
| irq_o | output | 4 | Per-core normal request |
| fiq_o | output | 4 | Per-core fast request |

## Verification
The bench sets both enable bits of a source together. A design that lets the normal class win, or sends the source to both words, would assert the normal output there. It moves the shared-line routing to every core and checks that only the selected core's bit 8 rises. A decoder that ignores the routing field, or uses the wrong one, would light the wrong core. It also writes all-ones to the routing and enable registers and to unmapped offsets. An implementation that stores unused bits, or aliases the unmapped space onto real registers, returns the wrong readback. Finally, it drops an input and reads the status word in the same cycle. A latched source word would still show the stale bit.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int NUM_CORES    = 4;
    localparam int SRC_PER_GRP  = 4;
    localparam int WORD_W       = 32;
    localparam int CORE_IDX_W   = $clog2(NUM_CORES);
    localparam int EN_W         = 2 * SRC_PER_GRP;
    localparam int SHARED_BIT   = 2 * SRC_PER_GRP;

    localparam logic [7:0] ROUTE_OFS   = 8'h0C;
    localparam logic [7:0] TMR_EN_BASE = 8'h40;
    localparam logic [7:0] MBX_EN_BASE = 8'h50;
    localparam logic [7:0] NRM_ST_BASE = 8'h60;
    localparam logic [7:0] FST_ST_BASE = 8'h70;

    typedef struct packed {
        logic [CORE_IDX_W-1:0] fast_core;
        logic [CORE_IDX_W-1:0] norm_core;
    } route_t;

    typedef struct packed {
        route_t                          route;
        logic [NUM_CORES-1:0][EN_W-1:0]  tmr_en;
        logic [NUM_CORES-1:0][EN_W-1:0]  mbx_en;
    } ctrl_t;
endpackage

// File: rtl/irq_steer_group.sv
// Splits one group of level sources between the normal and fast classes
module irq_steer_group
    import irq_steer_pkg::*;
(
    input  logic [SRC_PER_GRP-1:0] src_i,
    input  logic [EN_W-1:0]        en_i,
    output logic [SRC_PER_GRP-1:0] norm_o,
    output logic [SRC_PER_GRP-1:0] fast_o
);
    for (genvar j = 0; j < SRC_PER_GRP; j++) begin : g_src
        // fast enable takes priority; normal only if fast is clear
        assign fast_o[j] = src_i[j] & en_i[j+SRC_PER_GRP];
        assign norm_o[j] = src_i[j] & en_i[j] & ~en_i[j+SRC_PER_GRP];
    end
endmodule

// File: rtl/irq_steer_regs.sv
// Control storage and register decode
module irq_steer_regs
    import irq_steer_pkg::*;
(
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              valid_i,
    input  logic                              write_i,
    input  logic [7:0]                        addr_i,
    input  logic [WORD_W-1:0]                 wdata_i,
    input  logic [NUM_CORES-1:0][WORD_W-1:0]  norm_word_i,
    input  logic [NUM_CORES-1:0][WORD_W-1:0]  fast_word_i,
    output logic [WORD_W-1:0]                 rdata_o,
    output ctrl_t                             ctrl_o
);
    localparam int IDX_W = $clog2(NUM_CORES);

    ctrl_t ctrl_d, ctrl_q;

    logic [3:0]       hi_nib;
    logic [IDX_W-1:0] idx;
    assign hi_nib = addr_i[7:4];
    assign idx    = addr_i[2 +: IDX_W];

    always_comb begin
        ctrl_d  = ctrl_q;
        rdata_o = '0;
        if (valid_i) begin
            if (addr_i[7:2] == ROUTE_OFS[7:2]) begin
                if (write_i) ctrl_d.route = wdata_i[2*CORE_IDX_W-1:0];
                else         rdata_o[2*CORE_IDX_W-1:0] = ctrl_q.route;
            end else if (hi_nib == TMR_EN_BASE[7:4]) begin
                if (write_i) ctrl_d.tmr_en[idx] = wdata_i[EN_W-1:0];
                else         rdata_o[EN_W-1:0] = ctrl_q.tmr_en[idx];
            end else if (hi_nib == MBX_EN_BASE[7:4]) begin
                if (write_i) ctrl_d.mbx_en[idx] = wdata_i[EN_W-1:0];
                else         rdata_o[EN_W-1:0] = ctrl_q.mbx_en[idx];
            end else if (hi_nib == NRM_ST_BASE[7:4]) begin
                if (!write_i) rdata_o = norm_word_i[idx];
            end else if (hi_nib == FST_ST_BASE[7:4]) begin
                if (!write_i) rdata_o = fast_word_i[idx];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_steer_core.sv
// Builds the two source words of one core
module irq_steer_core
    import irq_steer_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic [SRC_PER_GRP-1:0] timer_i,
    input  logic [SRC_PER_GRP-1:0] mbox_i,
    input  logic [EN_W-1:0]        tmr_en_i,
    input  logic [EN_W-1:0]        mbx_en_i,
    input  logic                   shared_irq_i,
    input  logic                   shared_fiq_i,
    input  route_t                 route_i,
    output logic [WORD_W-1:0]      norm_word_o,
    output logic [WORD_W-1:0]      fast_word_o
);
    logic [SRC_PER_GRP-1:0] t_n, t_f, m_n, m_f;
    logic sh_n, sh_f;

    irq_steer_group u_tmr (.src_i(timer_i), .en_i(tmr_en_i), .norm_o(t_n), .fast_o(t_f));
    irq_steer_group u_mbx (.src_i(mbox_i),  .en_i(mbx_en_i), .norm_o(m_n), .fast_o(m_f));

    assign sh_n = shared_irq_i & (route_i.norm_core == CORE_IDX_W'(CORE_ID));
    assign sh_f = shared_fiq_i & (route_i.fast_core == CORE_IDX_W'(CORE_ID));

    assign norm_word_o = {{(WORD_W-SHARED_BIT-1){1'b0}}, sh_n, m_n, t_n};
    assign fast_word_o = {{(WORD_W-SHARED_BIT-1){1'b0}}, sh_f, m_f, t_f};
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_valid_i,
    input  logic        reg_write_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic [15:0] timer_i,
    input  logic [15:0] mbox_i,
    input  logic        shared_irq_i,
    input  logic        shared_fiq_i,
    output logic [3:0]  irq_o,
    output logic [3:0]  fiq_o
);
    ctrl_t ctrl;
    logic [NUM_CORES-1:0][WORD_W-1:0] norm_w, fast_w;

    irq_steer_regs u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .valid_i(reg_valid_i), .write_i(reg_write_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .norm_word_i(norm_w), .fast_word_i(fast_w),
        .rdata_o(reg_rdata_o), .ctrl_o(ctrl)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        irq_steer_core #(.CORE_ID(c)) u_core (
            .timer_i(timer_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .mbox_i(mbox_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .tmr_en_i(ctrl.tmr_en[c]),
            .mbx_en_i(ctrl.mbx_en[c]),
            .shared_irq_i(shared_irq_i),
            .shared_fiq_i(shared_fiq_i),
            .route_i(ctrl.route),
            .norm_word_o(norm_w[c]),
            .fast_word_o(fast_w[c])
        );
        assign irq_o[c] = |norm_w[c];
        assign fiq_o[c] = |fast_w[c];
    end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        reg_valid_i,
    input logic        reg_write_i,
    input logic [7:0]  reg_addr_i,
    input logic [31:0] reg_rdata_o,
    input logic [15:0] timer_i,
    input logic [15:0] mbox_i,
    input logic        shared_irq_i,
    input logic        shared_fiq_i,
    input logic [3:0]  irq_o,
    input logic [3:0]  fiq_o
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk_i)
        $past(!rst_ni) && !rst_ni |-> (irq_o == 4'b0 && fiq_o == 4'b0));

    // R8
    no_src_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timer_i == 16'b0 && mbox_i == 16'b0 && !shared_irq_i) |-> irq_o == 4'b0);

    // R8
    no_src_no_fiq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timer_i == 16'b0 && mbox_i == 16'b0 && !shared_fiq_i) |-> fiq_o == 4'b0);

    // R6
    shared_one_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timer_i == 16'b0 && mbox_i == 16'b0) |-> ($countones(irq_o) <= 1 && $countones(fiq_o) <= 1));

    // R5
    status_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_valid_i && !reg_write_i && reg_addr_i[7:5] == 3'b011) |-> reg_rdata_o[31:9] == '0);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_valid_i && !reg_write_i && reg_addr_i[7]) |-> reg_rdata_o == 32'b0);
endmodule

bind irq_steer_top irq_steer_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
    .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
    .timer_i(timer_i), .mbox_i(mbox_i),
    .shared_irq_i(shared_irq_i), .shared_fiq_i(shared_fiq_i),
    .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/irq_steer_tb.sv
module irq_steer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        vld = 0, wr = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [15:0] tmr = 0, mbx = 0;
    logic        s_irq = 0, s_fiq = 0;
    logic [3:0]  irq, fiq;

    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer_top dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_valid_i(vld), .reg_write_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .timer_i(tmr), .mbox_i(mbx),
        .shared_irq_i(s_irq), .shared_fiq_i(s_fiq),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, registered at next posedge
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        vld = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        vld = 0; wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        vld = 1; wr = 0; addr = a;
        #1;
        check(req, rdata, exp);
        vld = 0;
    endtask

    // vector table: core-0 timer enable, core-0 timer input, expected normal word, fast word
    typedef struct packed {
        logic [7:0]  en;
        logic [3:0]  src;
        logic [31:0] nrm;
        logic [31:0] fst;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{8'h0F, 4'hF, 32'h0F, 32'h00},
        '{8'hF0, 4'hF, 32'h00, 32'h0F},
        '{8'hFF, 4'h5, 32'h00, 32'h05},   // both set: fast only (R4)
        '{8'h00, 4'hF, 32'h00, 32'h00},   // masked
        '{8'h3C, 4'hF, 32'h0C, 32'h03},
        '{8'h0F, 4'h0, 32'h00, 32'h00}
    };

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", {28'b0, irq}, 0);
        check("R1 fiq", {28'b0, fiq}, 0);
        rst_n = 1;
        rd_chk("R1 route", 8'h0C, 0);
        rd_chk("R1 tmr_en", 8'h44, 0);
        rd_chk("R1 mbx_en", 8'h5C, 0);

        foreach (VECS[i]) begin
            wr_reg(8'h40, {24'h0, VECS[i].en});
            tmr[3:0] = VECS[i].src;
            rd_chk("R4 nrm", 8'h60, VECS[i].nrm);
            rd_chk("R4 fst", 8'h70, VECS[i].fst);
            check("R8 irq", {31'b0, irq[0]}, {31'b0, VECS[i].nrm != 0});
            check("R8 fiq", {31'b0, fiq[0]}, {31'b0, VECS[i].fst != 0});
        end
        tmr = 0;

        // R2 routing stores only [3:0]
        wr_reg(8'h0C, 32'hFFFF_FFF6);
        rd_chk("R2 route", 8'h0C, 32'h6);
        // R3 only low byte stored; low offset bits ignored
        wr_reg(8'h53, 32'hABCD_12F1);
        rd_chk("R3 mbx_en core0", 8'h50, 32'hF1);
        wr_reg(8'h58, 32'h0000_0102);
        rd_chk("R3 mbx_en core2", 8'h5A, 32'h02);

        // R5 mailbox bits 7:4; core 2 mailbox 1 to normal
        mbx[9] = 1;
        rd_chk("R5 mbx nrm core2", 8'h68, 32'h20);
        check("R8 irq core2", {28'b0, irq}, 32'h4);
        // R7 drop in same cycle
        @(negedge clk); vld = 1; wr = 0; addr = 8'h68; mbx[9] = 0; #1;
        check("R7 drop", rdata, 0); vld = 0;

        // R6 shared lines to each core
        s_irq = 1; s_fiq = 1;
        for (int c = 0; c < 4; c++) begin
            wr_reg(8'h0C, c | ((3 - c) << 2));
            rd_chk("R6 nrm", 8'h60 + 8'(4*c), 32'h100);
            rd_chk("R6 fst", 8'h70 + 8'(4*(3-c)), 32'h100);
            check("R6 irq onehot", {28'b0, irq}, 32'(1 << c));
            check("R6 fiq onehot", {28'b0, fiq}, 32'(1 << (3-c)));
        end
        s_irq = 0; s_fiq = 0;

        // R9 unmapped writes do nothing and read zero
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h84, 32'hFFFF_FFFF);
        wr_reg(8'hC8, 32'hFFFF_FFFF);
        wr_reg(8'h64, 32'hFFFF_FFFF);
        rd_chk("R9 route kept", 8'h0C, 32'h3);
        rd_chk("R9 mbx kept", 8'h50, 32'hF1);
        rd_chk("R9 tmr kept", 8'h40, 32'h0F);
        rd_chk("R9 unmapped", 8'h84, 0);
        rd_chk("R9 unmapped low", 8'h00, 0);

        // R1 reset again clears
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_chk("R1 route after reset", 8'h0C, 0);
        rd_chk("R1 tmr after reset", 8'h40, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule